// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer with Status and Interrupt

This block is the receive half of a USB device OUT endpoint. Received payload bytes arrive on a valid/ready byte stream, and each beat carries an end-of-packet marker. The bytes are stored in two alternating packet buffers. While one buffer is being filled from the packet side, the other is the active buffer that the CPU or a DMA reader drains through a byte pop port. A small status register reports the following:
- whether unread bytes remain;
- whether the active packet is short or zero-length;
- the DMA-mode setting;
- a packet-complete flag that is cleared by writing 1.

A level interrupt tells software when a packet is ready. With DMA mode off, it fires while the whole packet is still unread. With DMA mode on, it fires once fewer than a threshold of bytes remain, so the processor only has to collect the tail that the DMA transfer left behind.

Back-pressure works as follows. `in_ready` is low exactly while the buffer next in line for filling still holds an unreleased packet. A beat moves only on a cycle where both `in_valid` and `in_ready` are high. The source must keep its beat stable while `in_ready` is low. A zero-length packet is one beat with both `in_last` and `in_empty` high. A buffer is released once its bytes are drained and software has cleared packet-complete. On release, the other buffer becomes active.

Top module: `usb_out_rx_ep`

## Requirements
- R1: `in_ready` is 1 when fewer than two packets are held and 0 when two are held; a beat offered while `in_ready` is 0 is not stored.
- R2: Packets are read out in arrival order, and bytes are read in arrival order. `rd_data` shows the next unread byte of the active packet, and a pulse of `rd_en` advances past it.
- R3: A packet is limited to MAX_PKT (64) bytes. Further bytes before `in_last` are accepted and discarded, and such a packet reads as 64 bytes that are not short.
- R4: Status bit 2 (not-empty) is 1 exactly when the active packet has unread bytes.
- R5: Status bit 3 (short) is 1 when an active packet is present and it held fewer than 64 bytes. A zero-length packet shows bit 3 = 1 with bit 2 = 0. Bit 3 follows the new active packet after a release, and it is 0 when no packet is held.
- R6: Status bit 0 (packet-complete) is set at every end of packet and is cleared by writing 1 to it. A drained active buffer is released in the cycle after bit 0 reads 0. If the other buffer already holds a packet at that release, bit 0 is set again.
- R7: With status bit 1 (DMA mode) = 0, `irq` is 1 while bit 0 is 1, a packet is active, and none of its bytes has been read.
- R8: With status bit 1 = 1, `irq` is 1 while bit 0 is 1, a packet is active, and fewer than IRQ_THRESH (32) of its bytes remain unread.
- R9: A `rd_en` pulse while not-empty is 0 returns `rd_data` = 0 and moves no pointer.
- R10: Status bit 1 is read/write. Bits 7:4, including the reserved bits 5:4, always read 0, and writing them changes nothing. Writing 0 to bit 0 leaves it unchanged.
- R11: After reset, `csr_rdata` = 0, `irq` = 0, `in_ready` = 1 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet-side beat valid |
| in_ready | output | 1 | Packet-side buffer space available |
| in_data | input | 8 | Received payload byte |
| in_last | input | 1 | Beat ends the packet |
| in_empty | input | 1 | Beat carries no byte (zero-length packet marker) |
| rd_en | input | 1 | Pop one byte from the active packet |
| rd_data | output | 8 | Next unread byte of the active packet, or 0 |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status write data (bit 0 write-1-to-clear, bit 1 DMA mode) |
| csr_rdata | output | 8 | Status read value |
| irq | output | 1 | Receive interrupt level |

## Verification
The hardest state to reach is a release that happens while the second buffer is already full. That is the only point where packet-complete is set again without an incoming packet, and where the short flag jumps to a different packet. The directed part of the stimulus reaches it by queuing two packets before any read, offering a third that must stall, and then draining and clearing in turn. A long run of random beats, pops and status writes then crosses commits, releases and clear-writes in the same cycles. The DMA threshold boundary is covered by draining a 50-byte packet one byte at a time with DMA mode on.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int CSR_W   = 8;
  localparam int B_DONE  = 0;
  localparam int B_DMA   = 1;
  localparam int B_NE    = 2;
  localparam int B_SHORT = 3;
endpackage

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl #(
  parameter int MAX_PKT = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [usb_rx_pkg::BYTE_W-1:0] in_data,
  input  logic                         in_last,
  input  logic                         in_empty,
  input  logic [1:0]                   full_vec,
  output logic                         in_ready,
  output logic                         wr_en,
  output logic                         wr_buf,
  output logic [AW-1:0]                wr_addr,
  output logic [usb_rx_pkg::BYTE_W-1:0] wr_data,
  output logic                         commit,
  output logic                         commit_buf,
  output logic [CW-1:0]                commit_len
);
  logic          wsel;
  logic [CW-1:0] wcnt;
  logic          accept;
  logic          room;

  assign in_ready   = !full_vec[wsel];
  assign accept     = in_valid && in_ready;
  assign room       = wcnt < CW'(MAX_PKT);
  assign wr_en      = accept && !in_empty && room;
  assign wr_buf     = wsel;
  assign wr_addr    = wcnt[AW-1:0];
  assign wr_data    = in_data;
  assign commit     = accept && in_last;
  assign commit_buf = wsel;
  assign commit_len = wcnt + CW'(wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      wcnt <= '0;
    end else if (commit) begin
      wsel <= ~wsel;
      wcnt <= '0;
    end else if (wr_en) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(MAX_PKT));
endmodule

// File: rtl/rx_buf_store.sv
module rx_buf_store #(
  parameter int MAX_PKT = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_buf,
  input  logic [AW-1:0]                wr_addr,
  input  logic [usb_rx_pkg::BYTE_W-1:0] wr_data,
  input  logic                         commit,
  input  logic                         commit_buf,
  input  logic [CW-1:0]                commit_len,
  input  logic                         release_buf,
  input  logic                         rel_sel,
  input  logic                         rd_buf,
  input  logic [AW-1:0]                rd_addr,
  output logic [usb_rx_pkg::BYTE_W-1:0] rd_byte,
  output logic [1:0]                   full_vec,
  output logic [CW-1:0]                act_len,
  output logic                         act_short
);
  logic [usb_rx_pkg::BYTE_W-1:0] mem [2][MAX_PKT];
  logic [CW-1:0]                 len_q [2];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_buf][wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        full_vec[s] <= 1'b0;
        len_q[s]    <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (commit && commit_buf == 1'(s)) begin
          full_vec[s] <= 1'b1;
          len_q[s]    <= commit_len;
        end else if (release_buf && rel_sel == 1'(s)) begin
          full_vec[s] <= 1'b0;
        end
      end
    end
  end

  assign rd_byte   = mem[rd_buf][rd_addr];
  assign act_len   = len_q[rd_buf];
  assign act_short = len_q[rd_buf] < CW'(MAX_PKT);

  assert_commit_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full_vec[commit_buf]);
  assert_release_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_buf |-> full_vec[rel_sel]);
endmodule

// File: rtl/rx_drain_ctrl.sv
module rx_drain_ctrl #(
  parameter int MAX_PKT    = 64,
  parameter int IRQ_THRESH = 32,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    full_vec,
  input  logic [CW-1:0] act_len,
  input  logic          done,
  output logic          rsel,
  output logic [AW-1:0] rd_addr,
  output logic          act_full,
  output logic          other_full,
  output logic          not_empty,
  output logic          release_buf,
  output logic          rem_low,
  output logic          untouched
);
  logic [CW-1:0] rptr;
  logic [CW-1:0] remain;
  logic          pop;

  assign act_full    = full_vec[rsel];
  assign other_full  = full_vec[~rsel];
  assign not_empty   = act_full && (rptr < act_len);
  assign release_buf = act_full && !not_empty && !done;
  assign pop         = rd_en && not_empty;
  assign remain      = act_len - rptr;
  assign rem_low     = remain < CW'(IRQ_THRESH);
  assign untouched   = rptr == '0;
  assign rd_addr     = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel <= 1'b0;
      rptr <= '0;
    end else if (release_buf) begin
      rsel <= ~rsel;
      rptr <= '0;
    end else if (pop) begin
      rptr <= rptr + 1'b1;
    end
  end

  assert_rptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_full |-> rptr <= act_len);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !not_empty && !release_buf) |=> $stable(rptr));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import usb_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             commit,
  input  logic             release_buf,
  input  logic             other_full,
  input  logic             act_full,
  input  logic             act_short,
  input  logic             not_empty,
  input  logic             rem_low,
  input  logic             untouched,
  output logic             done,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             irq
);
  logic dma_en;
  logic clr_done;
  logic reset_done;

  assign clr_done   = csr_wr && csr_wdata[B_DONE];
  assign reset_done = release_buf && other_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      dma_en <= 1'b0;
    end else begin
      done <= (done && !clr_done) || commit || reset_done;
      if (csr_wr) dma_en <= csr_wdata[B_DMA];
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_DONE]  = done;
    csr_rdata[B_DMA]   = dma_en;
    csr_rdata[B_NE]    = not_empty;
    csr_rdata[B_SHORT] = act_full && act_short;
  end

  assign irq = done && act_full && (dma_en ? rem_low : untouched);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !commit && !reset_done) |=> !done);
  assert_dma_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> $stable(dma_en));
endmodule

// File: rtl/usb_out_rx_ep.sv
module usb_out_rx_ep #(
  parameter int MAX_PKT    = 64,
  parameter int IRQ_THRESH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_empty,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  output logic       irq
);
  localparam int AW = $clog2(MAX_PKT);
  localparam int CW = $clog2(MAX_PKT + 1);

  logic          wr_en, wr_buf, commit, commit_buf;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_byte;
  logic [CW-1:0] commit_len, act_len;
  logic [1:0]    full_vec;
  logic          act_short, rsel, act_full, other_full, not_empty;
  logic          release_buf, rem_low, untouched, done;

  rx_fill_ctrl #(.MAX_PKT(MAX_PKT)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_empty(in_empty), .full_vec(full_vec),
    .in_ready(in_ready), .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_buf(commit_buf),
    .commit_len(commit_len)
  );

  rx_buf_store #(.MAX_PKT(MAX_PKT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .commit_buf(commit_buf), .commit_len(commit_len),
    .release_buf(release_buf), .rel_sel(rsel), .rd_buf(rsel),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .full_vec(full_vec),
    .act_len(act_len), .act_short(act_short)
  );

  rx_drain_ctrl #(.MAX_PKT(MAX_PKT), .IRQ_THRESH(IRQ_THRESH)) u_drain (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .full_vec(full_vec),
    .act_len(act_len), .done(done), .rsel(rsel), .rd_addr(rd_addr),
    .act_full(act_full), .other_full(other_full), .not_empty(not_empty),
    .release_buf(release_buf), .rem_low(rem_low), .untouched(untouched)
  );

  rx_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .commit(commit), .release_buf(release_buf), .other_full(other_full),
    .act_full(act_full), .act_short(act_short), .not_empty(not_empty),
    .rem_low(rem_low), .untouched(untouched), .done(done),
    .csr_rdata(csr_rdata), .irq(irq)
  );

  assign rd_data = not_empty ? rd_byte : 8'h00;
endmodule

// File: tb/tb_usb_out_rx_ep.sv
`timescale 1ns/1ps
module tb_usb_out_rx_ep;
  localparam int MAXP = 64;
  localparam int THR  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_empty = 1'b0, rd_en = 1'b0, csr_wr = 1'b0;
  logic [7:0] in_data = '0, csr_wdata = '0;
  logic in_ready, irq;
  logic [7:0] rd_data, csr_rdata;

  always #2 clk = ~clk;

  usb_out_rx_ep dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
    .rd_en(rd_en), .rd_data(rd_data), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  int tests = 0, fails = 0;
  int mcnt = 0, hd = 0, rp = 0, bw = 0;
  bit mdone = 0, mdma = 0;
  int mlen [2];
  logic [7:0] mbuf [2][MAXP];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic check_outs();
    bit ne, sh, ei;
    int erd;
    ne  = mcnt > 0 && rp < mlen[hd];
    sh  = mcnt > 0 && mlen[hd] < MAXP;
    erd = ne ? int'(mbuf[hd][rp]) : 0;
    ei  = mdone && mcnt > 0 && (mdma ? (mlen[hd] - rp) < THR : rp == 0);
    chk(csr_rdata[0] == mdone, "R6 packet-complete bit", csr_rdata[0], mdone);
    chk(csr_rdata[1] == mdma, "R10 dma bit", csr_rdata[1], mdma);
    chk(csr_rdata[2] == ne, "R4 not-empty bit", csr_rdata[2], ne);
    chk(csr_rdata[3] == sh, "R5 short bit", csr_rdata[3], sh);
    chk(csr_rdata[7:4] == 4'h0, "R10 reserved bits", csr_rdata[7:4], 0);
    chk(int'(rd_data) == erd, "R2 / R9 read data", rd_data, erd);
    chk(irq == ei, "R7 or R8 irq", irq, ei);
  endtask

  // one clock of stimulus; model advances by the requirement rules
  task automatic step(input bit v, input logic [7:0] d, input bit last, input bit emp,
                      input bit rd, input bit wr, input logic [7:0] wd);
    bit acc, pop, rel, com, relset;
    int slot;
    in_valid = v; in_data = d; in_last = last; in_empty = emp;
    rd_en = rd; csr_wr = wr; csr_wdata = wd;
    #0;
    chk(in_ready == (mcnt < 2), "R1 in_ready", in_ready, mcnt < 2);
    acc    = v && mcnt < 2;
    slot   = (hd + mcnt) % 2;
    pop    = rd && mcnt > 0 && rp < mlen[hd];
    rel    = mcnt > 0 && rp == mlen[hd] && !mdone;
    com    = acc && last;
    relset = rel && mcnt == 2;
    if (acc && !emp && bw < MAXP) begin  // R3 bytes past 64 dropped
      mbuf[slot][bw] = d;
      bw++;
    end
    if (com) begin
      mlen[slot] = bw;
      bw = 0;
    end
    mdone = (mdone && !(wr && wd[0])) || com || relset;
    if (wr) mdma = wd[1];
    if (rel) begin
      hd = hd ^ 1;
      rp = 0;
    end else if (pop) rp++;
    mcnt = mcnt + int'(com) - int'(rel);
    @(posedge clk);
    @(negedge clk);
    #1;
    check_outs();
    in_valid = 0; rd_en = 0; csr_wr = 0; in_last = 0; in_empty = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic send(input int n);
    if (n == 0) step(1, 8'h00, 1, 1, 0, 0, 8'h00);
    for (int i = 0; i < n; i++) step(1, 8'($urandom), i == n - 1, 0, 0, 0, 8'h00);
  endtask

  task automatic drain();
    for (int i = 0; i < 80; i++)
      if (mcnt > 0 && rp < mlen[hd]) step(0, 8'h00, 0, 0, 1, 0, 8'h00);
  endtask

  task automatic clear_done();
    step(0, 8'h00, 0, 0, 0, 1, {6'b0, mdma, 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(csr_rdata == 8'h00, "R11 reset csr", csr_rdata, 0);
    chk(irq == 1'b0, "R11 reset irq", irq, 0);
    chk(in_ready == 1'b1, "R11 reset in_ready", in_ready, 1);
    chk(rd_data == 8'h00, "R11 reset rd_data", rd_data, 0);

    // R2 R7: ordinary short packet, DMA off
    send(10); idle(1); drain(); clear_done(); idle(2);
    // R9: pops on empty
    step(0, 8'h00, 0, 0, 1, 0, 8'h00); step(0, 8'h00, 0, 0, 1, 0, 8'h00);
    // R5: zero-length packet
    send(0); idle(1); step(0, 8'h00, 0, 0, 1, 0, 8'h00); clear_done(); idle(2);
    // R1 R3 R6: full, overlong, then blocked third
    send(64); send(70); send(5); idle(1);
    drain(); clear_done(); idle(2); drain(); clear_done(); idle(2);
    // R8: DMA threshold crossing
    step(0, 8'h00, 0, 0, 0, 1, 8'h02);
    send(50); idle(1); drain(); clear_done(); idle(2);
    // R10: reserved bits written, bit 0 written 0
    send(3); step(0, 8'h00, 0, 0, 0, 1, 8'hF0); idle(1);
    drain(); clear_done(); idle(2);

    for (int i = 0; i < 4000; i++) begin
      bit lst;
      lst = ($urandom % 20) == 0;
      step($urandom % 2, 8'($urandom), lst, lst && ($urandom % 4 == 0),
           $urandom % 2, ($urandom % 25) == 0, 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule